// File: doc/BRIEF.md
# Programmable Stage-Select Timer/Divider

This block is a synchronous timer built on a 16-stage binary ripple-style counter that advances on each cycle where the count-enable input `tick_i` is high. The count-enable stands in for an oscillator or an external clock. Two select inputs pick one of four counter stages as the output tap. A mode input chooses how that tap is used.

In divider mode the output is a continuous square wave at the tick rate divided by 2^N, where N is the selected stage. In one-shot mode the output changes level once, after 2^(N-1) ticks, and then holds. A sticky flag freezes the counter so that it cannot wrap. An inversion input flips the output level. Counting needs an arming event. This is either a master reset pulse or, when auto-reset is enabled, a power-on request. Any active reset clears the counter and gates the count off.

Top module: `prog_tap_timer`

## Requirements
- R1: After `rst_n` is released, the counter holds zero, the one-shot flag is clear, and `tmr_o` equals `inv_i`.
- R2: The counter advances by one on a cycle with `tick_i` high only when the block is armed, no reset is active, and no one-shot hold is in force. It is unchanged on a cycle with `tick_i` low.
- R3: The tap stage is chosen from {`sel_b_i`,`sel_a_i`]: 00 selects stage 13, 01 selects stage 10, 10 selects stage 8 and 11 selects stage 16. Stage N is counter bit N-1.
- R4: With `mode_i`=1, the output (non-inverted) goes high after 2^(N-1) ticks from a cleared counter, goes low again after 2^N ticks, and repeats with period 2^N.
- R5: With `mode_i`=0, the output (non-inverted) goes high after 2^(N-1) ticks from a cleared counter and then stays high while more ticks arrive, because the counter is frozen.
- R6: Once set, the one-shot level does not depend on later changes of the select inputs. Setting `mode_i` to 1 clears the latch, and on the next cycle the output follows the selected counter bit.
- R7: `inv_i`=1 drives the complement of the level that `inv_i`=0 would give.
- R8: While `mrst_i` is high, the counter is cleared and does not count, and the block becomes armed. Counting resumes on the cycle after `mrst_i` falls.
- R9: With `auto_dis_i`=0, `por_i` acts like a master reset: it clears the counter and arms the block. With `auto_dis_i`=1, `por_i` has no effect.
- R10: Until the block is first armed after `rst_n`, ticks do not advance the counter and the output stays at `inv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| por_i | input | 1 | Power-on reset request, honoured only when auto-reset is enabled |
| auto_dis_i | input | 1 | 1 disables the power-on auto-reset path |
| mrst_i | input | 1 | Master reset, active high, synchronous |
| tick_i | input | 1 | Count enable, one count per high cycle |
| sel_a_i | input | 1 | Tap select, low bit |
| sel_b_i | input | 1 | Tap select, high bit |
| mode_i | input | 1 | 1 = continuous divider, 0 = one-shot timer |
| inv_i | input | 1 | 1 = inverted output level |
| tmr_o | output | 1 | Timer / divider output |

## Verification
The bench measures the exact tick count at which each of the four taps first rises. A swapped select decode or an off-by-one stage index shows up as an edge a power of two early or late. In one-shot mode it keeps ticking well past the point where an unfrozen counter would wrap the tap bit. It also changes the select after the latch has set, so a design that stored no sticky state would drop its output. It applies `por_i` with auto-reset both disabled and enabled, and it sends ticks before any arming event. A design that ignored the enable would clear the counter mid-count, and one that counted before arming would give an early edge. The bench also holds the master reset during ticks and toggles the mode out of a latched one-shot, which catches counting through reset and a latch that never releases.

// File: rtl/prog_tap_timer_pkg.sv
package prog_tap_timer_pkg;

  // select code, written as {sel_b, sel_a}
  typedef enum logic [1:0] {
    TAP_BASE = 2'b00,
    TAP_A    = 2'b01,
    TAP_B    = 2'b10,
    TAP_AB   = 2'b11
  } tap_sel_e;

  function automatic tap_sel_e tap_code(input logic a, input logic b);
    return tap_sel_e'({b, a});
  endfunction

endpackage

// File: rtl/tap_timer_rst_ctrl.sv
module tap_timer_rst_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  input  logic auto_dis_i,
  input  logic mrst_i,
  output logic rst_int_n_o,
  output logic clr_o,
  output logic armed_o
);

  logic [1:0] sync_q;
  logic       armed_q, armed_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_int_n_o = sync_q[1];

  always_comb begin
    clr_o   = mrst_i | (por_i & ~auto_dis_i);
    armed_d = armed_q | clr_o;
  end

  always_ff @(posedge clk or negedge rst_int_n_o) begin
    if (!rst_int_n_o) armed_q <= 1'b0;
    else              armed_q <= armed_d;
  end

  assign armed_o = armed_q;

endmodule

// File: rtl/tap_timer_chain.sv
module tap_timer_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o
);

  logic [W:0]   carry;
  logic [W-1:0] q, d;

  assign carry[0] = adv_i;

  for (genvar i = 0; i < W; i++) begin : g_stage
    always_comb begin
      carry[i+1] = carry[i] & q[i];
      d[i]       = clr_i ? 1'b0 : (q[i] ^ carry[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end

  assign cnt_o = q;

endmodule

// File: rtl/tap_timer_out.sv
module tap_timer_out
  import prog_tap_timer_pkg::*;
#(
  parameter int W      = 16,
  parameter int STG_00 = 13,
  parameter int STG_01 = 10,
  parameter int STG_10 = 8,
  parameter int STG_11 = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] cnt_i,
  input  logic         sel_a_i,
  input  logic         sel_b_i,
  input  logic         mode_i,
  input  logic         inv_i,
  output logic         hold_o,
  output logic         flag_o,
  output logic         tmr_o
);

  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [IDX_W-1:0] IDX_00 = IDX_W'(STG_00 - 1);
  localparam logic [IDX_W-1:0] IDX_01 = IDX_W'(STG_01 - 1);
  localparam logic [IDX_W-1:0] IDX_10 = IDX_W'(STG_10 - 1);
  localparam logic [IDX_W-1:0] IDX_11 = IDX_W'(STG_11 - 1);

  logic [IDX_W-1:0] idx;
  logic             tap, shot, flag_q, flag_d, level;

  always_comb begin
    unique case (tap_code(sel_a_i, sel_b_i))
      TAP_BASE: idx = IDX_00;
      TAP_A:    idx = IDX_01;
      TAP_B:    idx = IDX_10;
      default:  idx = IDX_11;
    endcase
    tap    = cnt_i[idx];
    shot   = flag_q | tap;
    hold_o = ~mode_i & shot;
    if (clr_i || mode_i) flag_d = 1'b0;
    else                 flag_d = shot;
    level  = mode_i ? tap : shot;
    tmr_o  = level ^ inv_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/prog_tap_timer.sv
module prog_tap_timer #(
  parameter int CNT_W  = 16,
  parameter int STG_00 = 13,
  parameter int STG_01 = 10,
  parameter int STG_10 = 8,
  parameter int STG_11 = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  input  logic auto_dis_i,
  input  logic mrst_i,
  input  logic tick_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  logic mode_i,
  input  logic inv_i,
  output logic tmr_o
);

  logic             rst_int_n, clr, armed, hold, adv, flag;
  logic [CNT_W-1:0] cnt;

  tap_timer_rst_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_i       (por_i),
    .auto_dis_i  (auto_dis_i),
    .mrst_i      (mrst_i),
    .rst_int_n_o (rst_int_n),
    .clr_o       (clr),
    .armed_o     (armed)
  );

  always_comb adv = tick_i & armed & ~clr & ~hold;

  tap_timer_chain #(.W(CNT_W)) u_chain (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr_i (clr),
    .adv_i (adv),
    .cnt_o (cnt)
  );

  tap_timer_out #(
    .W(CNT_W), .STG_00(STG_00), .STG_01(STG_01), .STG_10(STG_10), .STG_11(STG_11)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (clr),
    .cnt_i   (cnt),
    .sel_a_i (sel_a_i),
    .sel_b_i (sel_b_i),
    .mode_i  (mode_i),
    .inv_i   (inv_i),
    .hold_o  (hold),
    .flag_o  (flag),
    .tmr_o   (tmr_o)
  );

endmodule

// File: rtl/prog_tap_timer_chk.sv
module prog_tap_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         mode_i,
  input logic         clr,
  input logic         armed,
  input logic         hold,
  input logic         flag,
  input logic [W-1:0] cnt
);

  // R8
  clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !flag));

  // R2
  no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr) |=> $stable(cnt));

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && armed && !clr && !hold) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R10
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !clr) |=> $stable(cnt));

  // R5
  shot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !mode_i && !clr) |=> flag);

  // R5
  shot_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !mode_i && !clr) |=> $stable(cnt));

  // R6
  mode_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i |=> !flag);

endmodule

bind prog_tap_timer prog_tap_timer_chk #(.W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick_i (tick_i),
  .mode_i (mode_i),
  .clr    (clr),
  .armed  (armed),
  .hold   (hold),
  .flag   (flag),
  .cnt    (cnt)
);

// File: tb/prog_tap_timer_test.sv
module prog_tap_timer_test;

  logic clk = 1'b0;
  logic rst_n, por_i, auto_dis_i, mrst_i, tick_i, sel_a_i, sel_b_i, mode_i, inv_i;
  logic tmr_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  // behavioural reference state
  int  m_cnt = 0;
  bit  m_flag = 0;
  bit  m_armed = 0;

  always #2 clk = ~clk;

  prog_tap_timer uut (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .auto_dis_i(auto_dis_i),
    .mrst_i(mrst_i), .tick_i(tick_i), .sel_a_i(sel_a_i), .sel_b_i(sel_b_i),
    .mode_i(mode_i), .inv_i(inv_i), .tmr_o(tmr_o)
  );

  function automatic int stage_of(bit a, bit b);
    if (!a && !b) return 13;
    if (a && !b)  return 10;
    if (!a && b)  return 8;
    return 16;
  endfunction

  function automatic bit model_out();
    bit tapv;
    tapv = ((m_cnt >> (stage_of(sel_a_i, sel_b_i) - 1)) & 1) != 0;
    if (mode_i) return tapv ^ inv_i;
    return (m_flag | tapv) ^ inv_i;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_flag = 0; m_armed = 0;
    end else begin
      bit tapv, reset_now;
      tapv = ((m_cnt >> (stage_of(sel_a_i, sel_b_i) - 1)) & 1) != 0;
      reset_now = mrst_i || (por_i && !auto_dis_i);
      if (reset_now) begin
        m_cnt = 0; m_flag = 0; m_armed = 1;
      end else if (mode_i) begin
        m_flag = 0;
        if (m_armed && tick_i) m_cnt = (m_cnt + 1) % 65536;
      end else if (m_flag || tapv) begin
        m_flag = 1;
      end else if (m_armed && tick_i) begin
        m_cnt = (m_cnt + 1) % 65536;
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (tmr_o !== model_out()) begin
        errors++;
        $display("FAIL %s stream: tmr_o=%0b expected=%0b cnt_ref=%0d", phase, tmr_o, model_out(), m_cnt);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic expect_out(input bit exp, input string tag);
    @(negedge clk);
    checks++;
    if (tmr_o !== exp) begin
      errors++;
      $display("FAIL %s: tmr_o=%0b expected=%0b", tag, tmr_o, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_i = 1'b0;
  endtask

  task automatic mr_pulse();
    mrst_i = 1'b1;
    @(posedge clk);
    #1 mrst_i = 1'b0;
  endtask

  task automatic pick(input bit a, input bit b);
    sel_a_i = a; sel_b_i = b;
  endtask

  task automatic tap_edges(input bit a, input bit b, input string tag);
    int half;
    pick(a, b);
    half = 1 << (stage_of(a, b) - 1);
    mr_pulse();
    ticks(half - 1);
    expect_out(1'b0, tag);
    #1 ticks(1);
    expect_out(1'b1, tag);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; por_i = 1'b0; auto_dis_i = 1'b1; mrst_i = 1'b0; tick_i = 1'b0;
    sel_a_i = 1'b0; sel_b_i = 1'b1; mode_i = 1'b1; inv_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);

    phase = "R1";
    expect_out(1'b0, "R1 reset level");
    #1 inv_i = 1'b1;
    expect_out(1'b1, "R7 inverted reset level");
    #1 inv_i = 1'b0;

    phase = "R10";
    ticks(300);
    expect_out(1'b0, "R10 unarmed ticks ignored");
    #1 phase = "R9";
    por_i = 1'b1; idle(1); por_i = 1'b0;
    ticks(200);
    expect_out(1'b0, "R9 por ignored when auto-reset disabled");

    #1 auto_dis_i = 1'b0;
    por_i = 1'b1; idle(1); por_i = 1'b0;
    ticks(127);
    expect_out(1'b0, "R9 por arms, stage 8 before edge");
    #1 ticks(1);
    expect_out(1'b1, "R4 stage 8 rise at 128");

    #1 phase = "R2";
    idle(50);
    expect_out(1'b1, "R2 no advance without tick");
    #1 ticks(127);
    expect_out(1'b1, "R2 cnt 255");
    #1 ticks(1);
    expect_out(1'b0, "R4 stage 8 fall at 256");

    #1 phase = "R9";
    mr_pulse();
    ticks(100);
    por_i = 1'b1; idle(1); por_i = 1'b0;
    ticks(100);
    expect_out(1'b0, "R9 por clears mid-count");
    #1 auto_dis_i = 1'b1;

    phase = "R3";
    tap_edges(1'b0, 1'b0, "R3 sel 00 stage 13");
    tap_edges(1'b1, 1'b0, "R3 sel 01 stage 10");
    tap_edges(1'b0, 1'b1, "R3 sel 10 stage 8");
    tap_edges(1'b1, 1'b1, "R3 sel 11 stage 16");
    phase = "R4";
    ticks(32767);
    expect_out(1'b1, "R4 stage 16 high before period end");
    #1 ticks(1);
    expect_out(1'b0, "R4 stage 16 period 65536");

    #1 phase = "R5";
    mode_i = 1'b0;
    pick(1'b0, 1'b0);
    mr_pulse();
    ticks(4095);
    expect_out(1'b0, "R5 one-shot before 4096");
    #1 ticks(1);
    expect_out(1'b1, "R5 one-shot at 4096");
    #1 ticks(10000);
    expect_out(1'b1, "R5 one-shot holds past wrap point");

    #1 phase = "R6";
    pick(1'b1, 1'b1);
    expect_out(1'b1, "R6 latch ignores select change");
    #1 mode_i = 1'b1;
    idle(1);
    expect_out(1'b0, "R6 mode 1 follows stage 16 tap");
    #1 pick(1'b0, 1'b0);
    expect_out(1'b1, "R6 mode 1 follows stage 13 tap");

    #1 phase = "R8";
    pick(1'b0, 1'b1);
    mrst_i = 1'b1; tick_i = 1'b1;
    idle(300);
    expect_out(1'b0, "R8 held master reset blocks counting");
    #1 mrst_i = 1'b0;
    idle(128);
    tick_i = 1'b0;
    expect_out(1'b1, "R8 counting resumes after release");

    #1 phase = "R7";
    mode_i = 1'b0; inv_i = 1'b1;
    mr_pulse();
    expect_out(1'b1, "R7 inverted one-shot idle");
    #1 ticks(128);
    expect_out(1'b0, "R7 inverted one-shot fired");
    #1 ticks(500);
    expect_out(1'b0, "R7 inverted one-shot holds");

    #1 idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule